// File: doc/BRIEF.md
# UART interrupt priority identification unit

This unit gathers the interrupt causes of a FIFO-based UART and presents them as one read-only, prioritised identification word plus a single registered interrupt request. Receive error flags, the receive data level, the character time-out flag, the transmit-holding-empty flag and two auto-baud events arrive as inputs. Each source has its own enable.

Software reads the identification word to learn which cause to service. During the cycle of that read, no new interrupt can be latched. An event that lands in that cycle is parked and merged one cycle later, so the following read reports it. Line-status errors stay pending until the line status register is read. The transmit-empty cause is latched on the rising edge of its flag. It is dropped either by an identification read that reports it or by a write to the holding register. The two auto-baud flags live outside the priority code and stay set until their own clear strobes arrive.

Top module: `uart_irq_ident`

## Requirements
- R1: Bit 0 of the word is low exactly when a prioritised (non-auto-baud) source is pending; while bit 0 is high, bits 3:1 read 000.
- R2: Bits 3:1 carry the highest-priority pending source. The order is line status 011, then receive data 010, then receive time-out 110, then transmit empty 001. No other value appears while bit 0 is low.
- R3: Any bit of the 4-bit error input (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break) latches the line-status source when its enable is high.
- R4: A pending line-status source is cleared by a line-status read strobe and is not cleared by an identification read.
- R5: In the cycle of an identification read, latched state takes no new events. An event arriving in that cycle becomes visible one clock later.
- R6: Bit 8 (auto-baud done) and bit 9 (auto-baud time-out) set only when their enable is high. Each clears only on its own clear strobe.
- R7: Bits 7:6 both equal the FIFO-enable input; bits 5:4 and 31:10 read 0.
- R8: After reset the word reads 0x00000001 (FIFO enable low) and the interrupt request is low.
- R9: The transmit-empty source latches on a rising edge of its flag. It clears on an identification read that reports code 001, or on a holding-register write strobe.
- R10: Receive data and receive time-out follow their input levels with no latching. When both are high, receive data wins.
- R11: The interrupt request equals, one clock later, the OR of the pending flag (bit 0 low), bit 8 and bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_err_i | input | 4 | Receive error events: overrun, parity, framing, break |
| rx_avail_i | input | 1 | Receive data level reached |
| rx_tmo_i | input | 1 | Character time-out flag |
| thre_i | input | 1 | Transmit holding register empty flag |
| thr_wr_i | input | 1 | Write strobe to the transmit holding register |
| ab_done_i | input | 1 | Auto-baud finished event |
| ab_tmo_i | input | 1 | Auto-baud time-out event |
| ab_done_clr_i | input | 1 | Clear strobe for the auto-baud done flag |
| ab_tmo_clr_i | input | 1 | Clear strobe for the auto-baud time-out flag |
| en_line_i | input | 1 | Enable for the line-status source |
| en_rxdata_i | input | 1 | Enable for the receive-data source |
| en_rxtmo_i | input | 1 | Enable for the receive time-out source |
| en_txe_i | input | 1 | Enable for the transmit-empty source |
| en_abok_i | input | 1 | Enable for the auto-baud done flag |
| en_abtmo_i | input | 1 | Enable for the auto-baud time-out flag |
| fifo_en_i | input | 1 | FIFO enable control, mirrored into bits 7:6 |
| iir_rd_i | input | 1 | Identification register read strobe |
| lsr_rd_i | input | 1 | Line status register read strobe |
| irq_o | output | 1 | Registered interrupt request |
| id_word_o | output | ID_W | Identification word |

## Verification
The collision that matters is an identification read in the same cycle as a line-status read and a fresh receive error. The clear from the line-status read must take effect at once, while the new error must be held back. The bench drives all three strobes in one cycle with a line error already pending. It expects the word to show no pending source right after that edge, and the line-status code one edge later. A second collision pairs an identification read with an auto-baud event, and bit 8 must rise one cycle late.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   typedef enum logic [2:0] {
      ID_NONE   = 3'b000,
      ID_TXE    = 3'b001,
      ID_RXDATA = 3'b010,
      ID_LINE   = 3'b011,
      ID_RXTMO  = 3'b110
   } irq_id_e;

   localparam int SRC_LINE  = 0;
   localparam int SRC_TXE   = 1;
   localparam int SRC_ABOK  = 2;
   localparam int SRC_ABTMO = 3;
   localparam int N_STICKY  = 4;

endpackage

// File: rtl/irq_sticky_cell.sv
module irq_sticky_cell (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic hold_i,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;
   logic defer_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q  <= 1'b0;
         defer_q <= 1'b0;
      end else if (hold_i) begin
         flag_q  <= flag_q & ~clr_i;
         defer_q <= defer_q | set_i;
      end else begin
         flag_q  <= (flag_q & ~clr_i) | set_i | defer_q;
         defer_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
   import uart_irq_pkg::*;
(
   input  logic    line_i,
   input  logic    rxdata_i,
   input  logic    rxtmo_i,
   input  logic    txe_i,
   output irq_id_e code_o,
   output logic    pend_o
);

   always_comb begin
      if (line_i)        code_o = ID_LINE;
      else if (rxdata_i) code_o = ID_RXDATA;
      else if (rxtmo_i)  code_o = ID_RXTMO;
      else if (txe_i)    code_o = ID_TXE;
      else               code_o = ID_NONE;
   end

   assign pend_o = line_i | rxdata_i | rxtmo_i | txe_i;

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int ID_W       = 32,
   parameter int N_ERR      = 4,
   parameter int FIFO_LSB   = 6,
   parameter int AB_OK_BIT  = 8,
   parameter int AB_TMO_BIT = 9
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_ERR-1:0] line_err_i,
   input  logic             rx_avail_i,
   input  logic             rx_tmo_i,
   input  logic             thre_i,
   input  logic             thr_wr_i,
   input  logic             ab_done_i,
   input  logic             ab_tmo_i,
   input  logic             ab_done_clr_i,
   input  logic             ab_tmo_clr_i,
   input  logic             en_line_i,
   input  logic             en_rxdata_i,
   input  logic             en_rxtmo_i,
   input  logic             en_txe_i,
   input  logic             en_abok_i,
   input  logic             en_abtmo_i,
   input  logic             fifo_en_i,
   input  logic             iir_rd_i,
   input  logic             lsr_rd_i,
   output logic             irq_o,
   output logic [ID_W-1:0]  id_word_o
);

   localparam int CODE_LSB = 1;
   localparam int CODE_W   = 3;
   localparam int FIFO_W   = 2;
   localparam int TOP_BIT  = (AB_TMO_BIT > AB_OK_BIT) ? AB_TMO_BIT : AB_OK_BIT;

   if (ID_W <= TOP_BIT) begin : g_bad_width
      $error("uart_irq_ident: ID_W too small for auto-baud bits");
   end
   if (N_ERR < 1) begin : g_bad_err
      $error("uart_irq_ident: N_ERR must be at least 1");
   end
   if (FIFO_LSB < CODE_LSB + CODE_W || FIFO_LSB + FIFO_W > AB_OK_BIT) begin : g_bad_fifo
      $error("uart_irq_ident: FIFO field overlaps another field");
   end

   logic                thre_d;
   logic [N_STICKY-1:0] set_v;
   logic [N_STICKY-1:0] clr_v;
   logic [N_STICKY-1:0] flag_v;
   irq_id_e             code;
   logic                pend;
   logic                irq_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) thre_d <= 1'b0;
      else         thre_d <= thre_i;
   end

   always_comb begin
      set_v            = '0;
      clr_v            = '0;
      set_v[SRC_LINE]  = en_line_i & (|line_err_i);
      clr_v[SRC_LINE]  = lsr_rd_i;
      set_v[SRC_TXE]   = en_txe_i & thre_i & ~thre_d;
      clr_v[SRC_TXE]   = thr_wr_i | (iir_rd_i & (code == ID_TXE));
      set_v[SRC_ABOK]  = en_abok_i & ab_done_i;
      clr_v[SRC_ABOK]  = ab_done_clr_i;
      set_v[SRC_ABTMO] = en_abtmo_i & ab_tmo_i;
      clr_v[SRC_ABTMO] = ab_tmo_clr_i;
   end

   for (genvar g = 0; g < N_STICKY; g++) begin : g_src
      irq_sticky_cell u_cell (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .hold_i (iir_rd_i),
         .set_i  (set_v[g]),
         .clr_i  (clr_v[g]),
         .flag_o (flag_v[g])
      );
   end

   irq_prio_enc u_enc (
      .line_i   (flag_v[SRC_LINE] & en_line_i),
      .rxdata_i (rx_avail_i & en_rxdata_i),
      .rxtmo_i  (rx_tmo_i & en_rxtmo_i),
      .txe_i    (flag_v[SRC_TXE] & en_txe_i),
      .code_o   (code),
      .pend_o   (pend)
   );

   always_comb begin
      id_word_o                                = '0;
      id_word_o[0]                             = ~pend;
      id_word_o[CODE_LSB +: CODE_W]            = code;
      id_word_o[FIFO_LSB +: FIFO_W]            = {FIFO_W{fifo_en_i}};
      id_word_o[AB_OK_BIT]                     = flag_v[SRC_ABOK];
      id_word_o[AB_TMO_BIT]                    = flag_v[SRC_ABTMO];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= pend | flag_v[SRC_ABOK] | flag_v[SRC_ABTMO];
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
   parameter int ID_W  = 32,
   parameter int N_ERR = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [N_ERR-1:0] line_err_i,
   input logic             ab_done_i,
   input logic             ab_done_clr_i,
   input logic             fifo_en_i,
   input logic             iir_rd_i,
   input logic             lsr_rd_i,
   input logic             irq_o,
   input logic [ID_W-1:0]  id_word_o
);

   // R1: idle word carries no code
   a_r1_idle_code_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      id_word_o[0] |-> id_word_o[3:1] == 3'b000);

   // R2: only legal codes while pending
   a_r2_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !id_word_o[0] |-> (id_word_o[3:1] == 3'b011 || id_word_o[3:1] == 3'b010 ||
                         id_word_o[3:1] == 3'b110 || id_word_o[3:1] == 3'b001));

   // R4: line-status read with no new or parked error removes the line code
   a_r4_lsr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lsr_rd_i && !iir_rd_i && line_err_i == '0 && $past(rst_ni) && !$past(iir_rd_i))
      |=> id_word_o[3:1] != 3'b011);

   // R5: no auto-baud flag rises across an identification read
   a_r5_frozen_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iir_rd_i && !ab_done_clr_i) |=> !$rose(id_word_o[8]));

   // R6: clear strobe drops the done flag when nothing refills it
   a_r6_ab_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ab_done_clr_i && !ab_done_i && $past(rst_ni) && !$past(iir_rd_i)) |=> !id_word_o[8]);

   // R7: mirrored FIFO bits and reserved field
   a_r7_fixed_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
      id_word_o[7:6] == {2{fifo_en_i}} && id_word_o[5:4] == 2'b00);

   // R11: request follows the word one clock later
   a_r11_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> irq_o == $past(!id_word_o[0] || id_word_o[8] || id_word_o[9]));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.ID_W(ID_W), .N_ERR(N_ERR)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .line_err_i    (line_err_i),
   .ab_done_i     (ab_done_i),
   .ab_done_clr_i (ab_done_clr_i),
   .fifo_en_i     (fifo_en_i),
   .iir_rd_i      (iir_rd_i),
   .lsr_rd_i      (lsr_rd_i),
   .irq_o         (irq_o),
   .id_word_o     (id_word_o)
);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;

   localparam int CLK_P = 10;
   localparam int NVEC  = 8;

   // vector: {err[3:0], rxdata, rxtmo, fifo, expected low nibble[3:0]}
   localparam logic [10:0] VEC [NVEC] = '{
      {4'b0000, 1'b0, 1'b0, 1'b0, 4'b0001},
      {4'b0001, 1'b0, 1'b0, 1'b1, 4'b0110},
      {4'b0010, 1'b1, 1'b0, 1'b0, 4'b0110},
      {4'b0100, 1'b0, 1'b1, 1'b1, 4'b0110},
      {4'b1000, 1'b0, 1'b0, 1'b0, 4'b0110},
      {4'b0000, 1'b1, 1'b0, 1'b1, 4'b0100},
      {4'b0000, 1'b0, 1'b1, 1'b0, 4'b1100},
      {4'b0000, 1'b1, 1'b1, 1'b1, 4'b0100}
   };

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [3:0]  line_err_i = '0;
   logic        rx_avail_i = 0, rx_tmo_i = 0, thre_i = 0, thr_wr_i = 0;
   logic        ab_done_i = 0, ab_tmo_i = 0, ab_done_clr_i = 0, ab_tmo_clr_i = 0;
   logic        en_line_i = 1, en_rxdata_i = 1, en_rxtmo_i = 1, en_txe_i = 1;
   logic        en_abok_i = 0, en_abtmo_i = 1, fifo_en_i = 0;
   logic        iir_rd_i = 0, lsr_rd_i = 0;
   logic        irq_o;
   logic [31:0] id_word_o;

   int n_chk  = 0;
   int n_fail = 0;

   uart_irq_ident dut (.*);

   always #(CLK_P/2) clk_i = ~clk_i;

   task automatic tick();
      @(posedge clk_i);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_P * 3);
      chk("R8 reset word", id_word_o, 32'h0000_0001);
      chk("R8 reset irq", {31'b0, irq_o}, 32'h0);
      @(negedge clk_i);
      rst_ni = 1'b1;
      tick();
      chk("R8 word after release", id_word_o, 32'h0000_0001);

      // table walk: R1 R2 R3 R7 R10
      for (int i = 0; i < NVEC; i++) begin
         fifo_en_i  = VEC[i][4];
         rx_avail_i = VEC[i][6];
         rx_tmo_i   = VEC[i][5];
         line_err_i = VEC[i][10:7];
         tick();
         line_err_i = '0;
         chk($sformatf("R2 R3 vector %0d", i), id_word_o,
             {24'b0, {2{VEC[i][4]}}, 2'b00, VEC[i][3:0]});
         rx_avail_i = 0; rx_tmo_i = 0; fifo_en_i = 0;
         lsr_rd_i = 1; tick(); lsr_rd_i = 0;
      end
      chk("R1 idle after table", id_word_o, 32'h1);

      // R9 transmit-empty latch and clears
      thre_i = 1; tick();
      chk("R9 txe latched", id_word_o, 32'h2);
      tick();
      chk("R11 irq raised", {31'b0, irq_o}, 32'h1);
      rx_avail_i = 1; #1;
      chk("R2 rxdata over txe", id_word_o, 32'h4);
      rx_avail_i = 0; #1;
      chk("R10 rxdata level drop", id_word_o, 32'h2);
      iir_rd_i = 1; tick(); iir_rd_i = 0;
      chk("R9 read clears txe", id_word_o, 32'h1);
      tick();
      chk("R11 irq dropped", {31'b0, irq_o}, 32'h0);
      thre_i = 0; tick(); thre_i = 1; tick();
      chk("R9 second edge", id_word_o, 32'h2);
      thr_wr_i = 1; tick(); thr_wr_i = 0;
      chk("R9 write clears txe", id_word_o, 32'h1);
      thre_i = 0; tick();

      // R4 line status clears only on its own read
      line_err_i = 4'b0100; tick(); line_err_i = '0;
      iir_rd_i = 1; tick(); iir_rd_i = 0;
      chk("R4 id read keeps line", id_word_o, 32'h6);
      lsr_rd_i = 1; tick(); lsr_rd_i = 0;
      chk("R4 lsr read clears", id_word_o, 32'h1);

      // R5 event during identification read is deferred
      iir_rd_i = 1; line_err_i = 4'b0001; tick(); iir_rd_i = 0; line_err_i = '0;
      chk("R5 frozen during read", id_word_o, 32'h1);
      tick();
      chk("R5 deferred appears", id_word_o, 32'h6);

      // R5 collision: id read + lsr read + new error in one cycle
      iir_rd_i = 1; lsr_rd_i = 1; line_err_i = 4'b1000; tick();
      iir_rd_i = 0; lsr_rd_i = 0; line_err_i = '0;
      chk("R5 clear applied in read cycle", id_word_o, 32'h1);
      tick();
      chk("R5 new error one cycle late", id_word_o, 32'h6);
      lsr_rd_i = 1; tick(); lsr_rd_i = 0;

      // R6 auto-baud flags
      ab_done_i = 1; tick(); ab_done_i = 0;
      chk("R6 disabled done ignored", id_word_o, 32'h1);
      en_abok_i = 1;
      ab_done_i = 1; tick(); ab_done_i = 0;
      chk("R6 done set", id_word_o, 32'h101);
      tick();
      chk("R11 irq from auto-baud", {31'b0, irq_o}, 32'h1);
      iir_rd_i = 1; tick(); iir_rd_i = 0;
      lsr_rd_i = 1; tick(); lsr_rd_i = 0;
      chk("R6 reads do not clear", id_word_o, 32'h101);
      ab_done_clr_i = 1; tick(); ab_done_clr_i = 0;
      chk("R6 done cleared", id_word_o, 32'h1);
      ab_tmo_i = 1; tick(); ab_tmo_i = 0;
      chk("R6 timeout set", id_word_o, 32'h201);
      ab_tmo_clr_i = 1; tick(); ab_tmo_clr_i = 0;
      chk("R6 timeout cleared", id_word_o, 32'h1);

      // R5 auto-baud event during read
      iir_rd_i = 1; ab_done_i = 1; tick(); iir_rd_i = 0; ab_done_i = 0;
      chk("R5 done held back", id_word_o, 32'h1);
      tick();
      chk("R5 done merged", id_word_o, 32'h101);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule